// File: doc/BRIEF.md
# Burst Page-Boundary Splitter

This block sits between an on-chip bus and a memory engine that drives a pseudo-static RAM. Such RAMs refuse a burst that runs across one of their internal pages, so every burst the bus asks for is cut into sub-bursts that each stay inside a single page. A burst request carries a start byte address, a beat count and a beat width of one or two bytes. Each sub-burst goes to the engine with its own valid/ready handshake. A single-cycle done pulse marks the end of the whole burst.

A 3-bit page-size code sets where the cuts fall. Code 0 turns splitting off. Codes 1 to 4 select pages of 128, 256, 512 or 1024 bytes. Codes 5 to 7 are not valid settings: the block treats them as code 0 and sets a sticky error flag. The code is sampled when a request is accepted and holds for the whole burst. Only addresses and lengths are handled here. Data movement and memory timing belong to the engine.

Top module: `burst_page_splitter`

## Requirements
- R1: With page code 0 a burst goes out as one sub-burst that has the request's address, beat count and width. After reset the stored effective code is 0.
- R2: Page codes 1, 2, 3 and 4 select pages of 128, 256, 512 and 1024 bytes, aligned to their own size. No sub-burst spans two pages.
- R3: The first sub-burst holds the lesser of the request's beat count and the number of beats left before the next page edge. Each later sub-burst holds the lesser of a full page's worth of beats and the beats still remaining.
- R4: Sub-bursts are issued in ascending address order. Each one starts at the byte that follows the last byte of the one before. Together their lengths add up to the request's beat count.
- R5: A sub-burst is offered on sub_valid and held with stable address, length and width until sub_ready accepts it. The next sub-burst is offered only after that acceptance.
- R6: done is high for exactly one cycle, in the cycle after the last sub-burst is accepted. req_ready is high only while no burst is in progress.
- R7: Page codes 5, 6 and 7 split like code 0. Accepting a request under one of these codes sets cfg_err, and cfg_err stays high until reset.
- R8: The page code and the request fields are sampled in the cycle the request is accepted. Changing them later during the burst does not affect its sub-bursts.
- R9: With req_wide = 1 each beat is 2 bytes. Address bit 0 is forced to zero on every sub-burst, and the room left in a page is counted in halfwords. With req_wide = 0 each beat is 1 byte.
- R10: A request with a beat count of 0 issues no sub-burst. done pulses in the cycle after that request is accepted.
- R11: After reset req_ready = 1, sub_valid = 0, done = 0 and cfg_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_code | input | 3 | Page-size code: 0 off, 1..4 = 128..1024 bytes, 5..7 invalid |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Ready for a new burst request |
| req_addr | input | ADDR_W | Start byte address |
| req_beats | input | LEN_W | Number of beats |
| req_wide | input | 1 | Beat width: 0 = 1 byte, 1 = 2 bytes |
| sub_valid | output | 1 | Sub-burst valid |
| sub_ready | input | 1 | Engine accepts the sub-burst |
| sub_addr | output | ADDR_W | Sub-burst start byte address |
| sub_beats | output | LEN_W | Sub-burst beat count |
| sub_wide | output | 1 | Sub-burst beat width |
| done | output | 1 | One-cycle pulse when the burst completes |
| cfg_err | output | 1 | Sticky flag: a request was accepted under an invalid page code |

## Verification
The bench targets bursts that start one beat before a page edge, bursts that start exactly on an edge, bursts that fill a page exactly, and halfword bursts at odd addresses. A design with an off-by-one in the room calculation would emit a sub-burst one beat too long or too short. A design that skipped forcing bit 0 to zero would give a misaligned address and a wrong room. The bench also changes the page code in the middle of a burst and applies heavy stalls on sub_ready. A design that read the code live, or moved on before acceptance, would then cut at the wrong place or drop a sub-burst. Zero-length requests and invalid codes are also sent. A design that got these wrong would hang waiting for a sub-burst, split a burst it should leave whole, or lose the error flag.

// File: rtl/pgsplit_pkg.sv
package pgsplit_pkg;

  // Width of the in-page offset, sized for the largest page (1024 bytes).
  localparam int PG_OFS_W = 11;
  localparam logic [2:0] PG_CODE_MAX = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1
  } pgs_state_e;

  // True for codes that are not defined settings.
  function automatic logic code_reserved(input logic [2:0] code);
    return code > PG_CODE_MAX;
  endfunction

  // True for codes that request splitting.
  function automatic logic code_splits(input logic [2:0] code);
    return (code != 3'd0) && (code <= PG_CODE_MAX);
  endfunction

  // Page size in bytes; 0 when splitting is off.
  function automatic logic [PG_OFS_W-1:0] page_bytes(input logic [2:0] code);
    logic [PG_OFS_W-1:0] sz;
    case (code)
      3'd1:    sz = PG_OFS_W'(128);
      3'd2:    sz = PG_OFS_W'(256);
      3'd3:    sz = PG_OFS_W'(512);
      3'd4:    sz = PG_OFS_W'(1024);
      default: sz = '0;
    endcase
    return sz;
  endfunction

  // Beats left before the next page edge, from the low address bits.
  function automatic logic [PG_OFS_W-1:0] edge_beats(input logic [PG_OFS_W-1:0] low,
                                                     input logic [2:0] code,
                                                     input logic wide);
    logic [PG_OFS_W-1:0] sz;
    logic [PG_OFS_W-1:0] ofs;
    logic [PG_OFS_W-1:0] room;
    sz   = page_bytes(code);
    ofs  = low & (sz - PG_OFS_W'(1));
    room = sz - ofs;
    return wide ? (room >> 1) : room;
  endfunction

endpackage

// File: rtl/pgsplit_cfg.sv
module pgsplit_cfg
  import pgsplit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] page_code,
  input  logic       accept,
  output logic [2:0] act_code,
  output logic       split_en,
  output logic       cfg_err
);

  logic reserved_now;
  assign reserved_now = code_reserved(page_code);

  // The effective code is captured at acceptance; invalid codes fold to 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= 3'd0;
      cfg_err  <= 1'b0;
    end else if (accept) begin
      act_code <= reserved_now ? 3'd0 : page_code;
      cfg_err  <= cfg_err | reserved_now;
    end
  end

  assign split_en = code_splits(act_code);

  // R7: once set, the flag stays until reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R7: an accepted invalid code raises the flag
  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reserved_now) |=> cfg_err);

  // R7: an invalid code never becomes the effective code
  a_r7_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reserved_now) |=> !split_en);

endmodule

// File: rtl/pgsplit_cut.sv
module pgsplit_cut
  import pgsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic              wide,
  input  logic [2:0]        code,
  output logic [LEN_W-1:0]  sub_len,
  output logic              cut_at_edge
);

  localparam int CW = (LEN_W > PG_OFS_W) ? LEN_W : PG_OFS_W;

  logic [PG_OFS_W-1:0] room_beats;
  logic [CW-1:0]       room_x;
  logic [CW-1:0]       rem_x;

  always_comb begin
    room_beats  = edge_beats(cur_addr[PG_OFS_W-1:0], code, wide);
    room_x      = CW'(room_beats);
    rem_x       = CW'(remain);
    cut_at_edge = code_splits(code) && (room_x < rem_x);
    sub_len     = cut_at_edge ? LEN_W'(room_beats) : remain;
  end

endmodule

// File: rtl/pgsplit_seq.sv
module pgsplit_seq
  import pgsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_beats,
  input  logic              req_wide,
  output logic              req_ready,
  output logic              accept,
  input  logic              sub_ready,
  input  logic [LEN_W-1:0]  sub_len,
  output logic              sub_valid,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic              wide_q,
  output logic              done
);

  pgs_state_e state;
  logic       fire;
  logic       last_fire;
  logic       zero_req;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign zero_req  = (req_beats == '0);
  assign sub_valid = (state == ST_ISSUE);
  assign fire      = sub_valid && sub_ready;
  assign last_fire = fire && (sub_len == remain);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      wide_q   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= (accept && zero_req) || last_fire;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_addr <= req_wide ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
            remain   <= req_beats;
            wide_q   <= req_wide;
            if (!zero_req) state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (fire) begin
            cur_addr <= cur_addr + (ADDR_W'(sub_len) << wide_q);
            remain   <= remain - sub_len;
            if (last_fire) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: an offered sub-burst is held until it is taken
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !sub_ready) |=> (sub_valid && $stable(cur_addr) && $stable(remain)));

  // R4: after a non-final acceptance the next sub-burst starts elsewhere with less left
  a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last_fire) |=> (sub_valid && (remain < $past(remain)) && (cur_addr != $past(cur_addr))));

  // R6: done only fires once the block is idle again
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  // R10: an empty request ends at once without a sub-burst
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && zero_req) |=> (done && !sub_valid));

  // R9: halfword sub-bursts always start on an even byte
  a_r9_even: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && wide_q) |-> !cur_addr[0]);

  // R3: a sub-burst is never empty and never larger than what is left
  a_r3_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> ((sub_len != '0) && (sub_len <= remain)));

endmodule

// File: rtl/burst_page_splitter.sv
module burst_page_splitter
  import pgsplit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        page_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_beats,
  input  logic              req_wide,
  output logic              sub_valid,
  input  logic              sub_ready,
  output logic [ADDR_W-1:0] sub_addr,
  output logic [LEN_W-1:0]  sub_beats,
  output logic              sub_wide,
  output logic              done,
  output logic              cfg_err
);

  logic              accept;
  logic [2:0]        act_code;
  logic              split_en;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic              wide_q;
  logic [LEN_W-1:0]  sub_len;
  logic              cut_at_edge;

  pgsplit_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .page_code (page_code),
    .accept    (accept),
    .act_code  (act_code),
    .split_en  (split_en),
    .cfg_err   (cfg_err)
  );

  pgsplit_cut #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cut (
    .cur_addr    (cur_addr),
    .remain      (remain),
    .wide        (wide_q),
    .code        (act_code),
    .sub_len     (sub_len),
    .cut_at_edge (cut_at_edge)
  );

  pgsplit_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_beats (req_beats),
    .req_wide  (req_wide),
    .req_ready (req_ready),
    .accept    (accept),
    .sub_ready (sub_ready),
    .sub_len   (sub_len),
    .sub_valid (sub_valid),
    .cur_addr  (cur_addr),
    .remain    (remain),
    .wide_q    (wide_q),
    .done      (done)
  );

  assign sub_addr  = cur_addr;
  assign sub_beats = sub_len;
  assign sub_wide  = wide_q;

  // Byte span of the offered sub-burst, measured from the start of its page.
  logic [PG_OFS_W+LEN_W:0] span_end;
  logic [PG_OFS_W-1:0]     pg_sz;
  always_comb begin
    pg_sz    = page_bytes(act_code);
    span_end = (PG_OFS_W+LEN_W+1)'(cur_addr[PG_OFS_W-1:0] & (pg_sz - PG_OFS_W'(1)))
             + ((PG_OFS_W+LEN_W+1)'(sub_len) << wide_q);
  end

  // R2: a split sub-burst ends at or before its page edge
  a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && split_en) |-> (span_end <= (PG_OFS_W+LEN_W+1)'(pg_sz)));

  // R1: with splitting off the whole remainder goes out at once
  a_r1_whole: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !split_en) |-> (sub_beats == remain));

  // R3: a cut only happens while splitting is on
  a_r3_cut_split: assert property (@(posedge clk) disable iff (!rst_n)
    cut_at_edge |-> split_en);

  // R6: no new request is taken while sub-bursts are pending
  a_r6_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sub_valid |-> !req_ready);

endmodule

// File: tb/burst_page_splitter_bench.sv
module burst_page_splitter_bench;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        page_code = 3'd0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_beats = '0;
  logic              req_wide = 1'b0;
  logic              sub_valid;
  logic              sub_ready = 1'b1;
  logic [ADDR_W-1:0] sub_addr;
  logic [LEN_W-1:0]  sub_beats;
  logic              sub_wide;
  logic              done;
  logic              cfg_err;

  always #2 clk = ~clk;

  burst_page_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_burst_page_splitter (
    .clk(clk), .rst_n(rst_n), .page_code(page_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_beats(req_beats), .req_wide(req_wide),
    .sub_valid(sub_valid), .sub_ready(sub_ready), .sub_addr(sub_addr),
    .sub_beats(sub_beats), .sub_wide(sub_wide), .done(done), .cfg_err(cfg_err)
  );

  typedef struct {
    logic [31:0] addr;
    int          len;
    bit          wide;
    bit          last;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   exp_done = 0;
  int   done_seen = 0;
  bit   stall_on = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Scoreboard driver: expand the request beat by beat and queue the pieces.
  task automatic send(input logic [31:0] addr, input int beats, input bit wide,
                      input logic [2:0] code, input string tag, input bit scramble);
    int          page;
    int          bytes;
    logic [31:0] a;
    logic [31:0] start;
    int          n;
    exp_t        it;
    page  = (code >= 3'd1 && code <= 3'd4) ? (64 << code) : 0;
    bytes = wide ? 2 : 1;
    a     = wide ? (addr & 32'hFFFF_FFFE) : addr;
    start = a;
    n     = 0;
    for (int i = 0; i < beats; i++) begin
      if (n > 0 && page != 0 && (a % page) == 0) begin
        it.addr = start; it.len = n; it.wide = wide; it.last = 1'b0; it.tag = tag;
        q.push_back(it);
        start = a;
        n = 0;
      end
      n++;
      a = a + bytes;
    end
    if (n > 0) begin
      it.addr = start; it.len = n; it.wide = wide; it.last = 1'b1; it.tag = tag;
      q.push_back(it);
    end
    exp_done++;
    page_code = code;
    req_addr  = addr;
    req_beats = LEN_W'(beats);
    req_wide  = wide;
    req_valid = 1'b1;
    begin
      bit acc;
      do begin
        @(negedge clk);
        acc = req_ready;
        @(posedge clk);
        #1;
      end while (!acc);
    end
    req_valid = 1'b0;
    if (scramble) begin
      // R8: these changes come after acceptance and must not matter
      page_code = 3'd0;
      req_addr  = 32'hDEAD_BEE1;
      req_beats = 8'd3;
      req_wide  = ~wide;
    end
    wait (done_seen == exp_done);
    @(posedge clk);
    #1;
  endtask

  // Engine-side ready pattern.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    sub_ready = stall_on ? (lfsr[1] & lfsr[4]) : 1'b1;
  end

  // Monitor: compare offered sub-bursts and done pulses against the queue.
  bit          done_pend = 1'b0;
  bit          hold_prev = 1'b0;
  logic [31:0] hold_addr;
  logic [7:0]  hold_len;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_pend) begin
        chk(done === 1'b1, "R6", "done after last acceptance", longint'(done), 1);
        done_pend = 1'b0;
      end else if (done === 1'b1) begin
        chk(1'b0, "R6", "unexpected done", 1, 0);
      end
      if (hold_prev) begin
        chk(sub_valid && sub_addr == hold_addr && sub_beats == hold_len, "R5",
            "held sub-burst changed", longint'(sub_addr), longint'(hold_addr));
      end
      if (sub_valid) chk(req_ready === 1'b0, "R6", "req_ready while busy", longint'(req_ready), 0);
      if (sub_valid && sub_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R4", "sub-burst with empty queue", longint'(sub_addr), 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(sub_addr == it.addr, it.tag, "sub_addr", longint'(sub_addr), longint'(it.addr));
          chk(int'(sub_beats) == it.len, it.tag, "sub_beats", longint'(sub_beats), longint'(it.len));
          chk(sub_wide == it.wide, it.tag, "sub_wide", longint'(sub_wide), longint'(it.wide));
          if (it.last) done_pend = 1'b1;
        end
      end
      if (req_valid && req_ready && req_beats == '0) done_pend = 1'b1;
      hold_prev = sub_valid && !sub_ready;
      hold_addr = sub_addr;
      hold_len  = sub_beats;
      if (done === 1'b1) done_seen++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    chk(req_ready === 1'b1, "R11", "req_ready in reset", longint'(req_ready), 1);
    chk(sub_valid === 1'b0, "R11", "sub_valid in reset", longint'(sub_valid), 0);
    chk(done === 1'b0, "R11", "done in reset", longint'(done), 0);
    chk(cfg_err === 1'b0, "R11", "cfg_err in reset", longint'(cfg_err), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    #1;

    send(32'h0000_0100, 40, 1'b0, 3'd0, "R1", 1'b0);
    send(32'h0000_0070, 40, 1'b0, 3'd1, "R3", 1'b0);
    send(32'h0000_0000, 128, 1'b0, 3'd1, "R2", 1'b0);
    send(32'h0000_0000, 255, 1'b0, 3'd1, "R2", 1'b0);
    send(32'h0000_01FF, 255, 1'b0, 3'd3, "R3", 1'b0);
    send(32'h0000_00F0, 200, 1'b1, 3'd2, "R9", 1'b0);
    send(32'h0000_03FE, 255, 1'b1, 3'd4, "R9", 1'b0);
    send(32'h0000_007F, 70, 1'b1, 3'd1, "R9", 1'b0);
    stall_on = 1'b1;
    send(32'h0000_0040, 255, 1'b0, 3'd1, "R5", 1'b0);
    send(32'h0000_0000, 255, 1'b0, 3'd1, "R8", 1'b1);
    send(32'h0000_0020, 0, 1'b0, 3'd2, "R10", 1'b0);
    chk(cfg_err === 1'b0, "R7", "cfg_err before invalid code", longint'(cfg_err), 0);
    send(32'h0000_0070, 200, 1'b0, 3'd6, "R7", 1'b0);
    @(negedge clk);
    chk(cfg_err === 1'b1, "R7", "cfg_err after invalid code", longint'(cfg_err), 1);
    @(posedge clk);
    #1;
    send(32'h0000_0170, 100, 1'b0, 3'd1, "R4", 1'b0);
    @(negedge clk);
    chk(cfg_err === 1'b1, "R7", "cfg_err sticky", longint'(cfg_err), 1);
    @(posedge clk);
    #1;
    for (int k = 0; k < 12; k++) begin
      send($urandom & 32'h0000_FFFF, int'($urandom % 256), 1'($urandom),
           3'($urandom % 5), "R4", 1'($urandom));
    end
    @(negedge clk);
    chk(q.size() == 0, "R4", "leftover expected sub-bursts", longint'(q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule